// File: doc/BRIEF.md
# Synchronous Rectifier Deadtime and Mode Controller

This block drives the high-side (PWM) and low-side (synchronous rectifier, SR) gate commands for each phase of a multi-phase buck regulator. It uses a shared counter-comparator modulator. Phase `p` sees the shared count plus a fixed offset of `p*P/NPH`, where `P = 2**CW` counts is the switching period. At the start of its own period, each phase takes a snapshot of four things: the duty command, a deadtime pair, the minimum-duty threshold, and the operating mode. The deadtime pair (turn-on and turn-off) is looked up from a 16-entry table. The table is indexed by the upper four bits of the load-current code.

The SR window starts `td_off` counts after the PWM falling edge. It closes `td_on` counts before the next PWM rising edge. The block has no explicit mode state machine. Light-load behaviour comes only from table entries with longer turn-on deadtimes and from dropping periods whose duty is under a programmable minimum. A one-bit serial register port writes the table entries and the minimum duty.

Top module: `sr_deadtime_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every `pwm_o` and `sr_o` bit is 0 and every phase reports mode SKIP (code 2). Reset loads every table entry with turn-on 2 and turn-off 2, and sets the minimum duty to 0.
- R2: The phase count of phase p is `(cnt + p*P/NPH) mod P`, where `cnt` is 0 in the first cycle after reset and advances by one each clock. When a period is not skipped, `pwm_o[p]` is 1 exactly when the phase count is below the latched duty D.
- R3: When a period is not skipped and is not suppressed, `sr_o[p]` is 1 exactly when the phase count lies in the range from `D + td_off` up to `P - td_on - 1`, inclusive.
- R4: The deadtime pair is taken from table entry `load_i[LW-1 -: 4]`. A serial frame is `5 + 2*TW` bits long and is sent MSB first on `ser_dat_i`, one bit per clock while `ser_en_i` is 1. The frame holds a 5-bit address, then turn-on (TW bits), then turn-off (TW bits). Address 0..15 writes that table entry. Address 16 writes the minimum duty from the low CW bits of the frame. The write takes effect when `ser_en_i` falls.
- R5: A frame with the wrong number of bits is ignored. A frame addressed above 16 is also ignored. Neither changes any table entry or the minimum duty.
- R6: If the latched duty is below the minimum duty, both gates stay 0 for that whole period and the mode reads SKIP (2). A duty equal to the minimum is not skipped.
- R7: If `D + td_off + td_on >= P`, the SR stays 0 for that whole period. PWM still runs normally.
- R8: A period that is not skipped reports CCM (0) when its turn-on deadtime equals the smallest turn-on value in the table. Otherwise it reports DCM (1).
- R9: Duty, load code, table contents and minimum duty are sampled only when a phase count is 0. A change made in the middle of a period takes effect in the next period.
- R10: `pwm_o[p]` and `sr_o[p]` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_i | input | CW | Duty command in counts of the period |
| load_i | input | LW | Load-current code; the upper 4 bits select the table entry |
| ser_en_i | input | 1 | Serial frame enable |
| ser_dat_i | input | 1 | Serial data, MSB first |
| pwm_o | output | NPH | High-side gate, one bit per phase |
| sr_o | output | NPH | Low-side gate, one bit per phase |
| mode_o | output | 2*NPH | Per-phase mode: 0 CCM, 1 DCM, 2 SKIP |

## Verification
The bench programs a table whose entries have distinct turn-on and turn-off values. It then sweeps duties from 0 to full scale against load codes that pick entries with short and long turn-on deadtimes. Every phase is compared with an arithmetic model over a whole period, so the sweep separates duty edges, deadtime edges, phase offsets, CCM/DCM reporting and SR suppression. Separate patterns cover three more cases: duties on either side of the minimum (skipping), short or out-of-range frames that must change nothing, and a duty change in the middle of a period that must wait for the next boundary.

// File: rtl/srm_pkg.sv
// Shared definitions for the SR deadtime controller.
package srm_pkg;
    localparam int ADDR_W    = 5;
    localparam int DMIN_ADDR = 16;
    localparam int NENT      = 16;

    typedef enum logic [1:0] {
        MODE_CCM  = 2'd0,
        MODE_DCM  = 2'd1,
        MODE_SKIP = 2'd2
    } srm_mode_e;
endpackage

// File: rtl/srm_cfg_port.sv
// Serial configuration port plus deadtime table and minimum-duty register.
// Assumes frames arrive MSB first, one bit per clock while ser_en_i is high;
// a frame commits on the falling edge of ser_en_i only if exactly FW bits came.
module srm_cfg_port
    import srm_pkg::*;
#(
    parameter int CW      = 10,
    parameter int TW      = 10,
    parameter int DEF_ON  = 2,
    parameter int DEF_OFF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_en_i,
    input  logic          ser_dat_i,
    input  logic [3:0]    rd_idx_i,
    output logic [TW-1:0] rd_ton_o,
    output logic [TW-1:0] rd_toff_o,
    output logic [CW-1:0] dmin_o,
    output logic [TW-1:0] min_ton_o
);
    localparam int DW  = 2 * TW;
    localparam int FW  = ADDR_W + DW;
    localparam int BCW = $clog2(FW + 2);

    logic [FW-1:0]     sh_q;
    logic [BCW-1:0]    bcnt_q;
    logic              en_q;
    logic [TW-1:0]     ton_q  [NENT];
    logic [TW-1:0]     toff_q [NENT];
    logic [CW-1:0]     dmin_q;
    logic              commit;
    logic              frame_end;
    logic [ADDR_W-1:0] waddr;

    assign frame_end = en_q && !ser_en_i;
    assign commit    = frame_end && (bcnt_q == BCW'(FW));
    assign waddr     = sh_q[FW-1 -: ADDR_W];

    // Shift in serial bits and count them, saturating just past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bcnt_q <= '0;
            en_q   <= 1'b0;
        end else begin
            en_q <= ser_en_i;
            if (ser_en_i) begin
                sh_q <= {sh_q[FW-2:0], ser_dat_i};
                if (bcnt_q != BCW'(FW + 1)) bcnt_q <= bcnt_q + 1'b1;
            end else begin
                bcnt_q <= '0;
            end
        end
    end

    // Deadtime table write on a committed frame addressed to an entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                ton_q[e]  <= TW'(DEF_ON);
                toff_q[e] <= TW'(DEF_OFF);
            end
        end else if (commit && (waddr < ADDR_W'(NENT))) begin
            ton_q[waddr[3:0]]  <= sh_q[DW-1 -: TW];
            toff_q[waddr[3:0]] <= sh_q[TW-1:0];
        end
    end

    // Minimum-duty register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   dmin_q <= '0;
        else if (commit && waddr == ADDR_W'(DMIN_ADDR)) dmin_q <= sh_q[CW-1:0];
    end

    // Smallest turn-on deadtime in the table, used as the CCM reference.
    always_comb begin
        min_ton_o = ton_q[0];
        for (int e = 1; e < NENT; e++)
            if (ton_q[e] < min_ton_o) min_ton_o = ton_q[e];
    end

    assign rd_ton_o  = ton_q[rd_idx_i];
    assign rd_toff_o = toff_q[rd_idx_i];
    assign dmin_o    = dmin_q;

    AST_BAD_FRAME_KEEPS_DMIN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bcnt_q != BCW'(FW)) |=> $stable(dmin_q)); // R5
    AST_BAD_FRAME_KEEPS_E0: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bcnt_q != BCW'(FW)) |=> $stable(ton_q[0])); // R5
endmodule

// File: rtl/srm_phase_slice.sv
// One phase: latches the period parameters at its own period start and forms
// registered PWM and SR gates from the next phase count, so each output bit
// matches the count the top holds in the same cycle.
// Assumes TW <= CW and that the shared count advances by one every clock.
module srm_phase_slice
    import srm_pkg::*;
#(
    parameter int CW  = 10,
    parameter int TW  = 10,
    parameter int OFS = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_n_i,
    input  logic [CW-1:0] duty_i,
    input  logic [CW-1:0] dmin_i,
    input  logic [TW-1:0] ton_i,
    input  logic [TW-1:0] toff_i,
    input  logic [TW-1:0] min_ton_i,
    output logic          pwm_o,
    output logic          sr_o,
    output logic [1:0]    mode_o
);
    localparam int P  = 2 ** CW;
    localparam int SW = CW + 2;

    logic [CW-1:0] pc_n;
    logic [CW-1:0] d_q, d_n;
    logic [TW-1:0] ton_q, ton_n, toff_q, toff_n;
    logic          skip_q, skip_n, srok_q, srok_n;
    srm_mode_e     mode_q, mode_n;
    logic [SW-1:0] s_edge, r_edge;
    logic          pwm_q, sr_q, pwm_n, sr_n;

    assign pc_n = cnt_n_i + CW'(OFS);

    // Snapshot the period parameters when this phase's count wraps to zero.
    always_comb begin
        d_n    = d_q;
        ton_n  = ton_q;
        toff_n = toff_q;
        skip_n = skip_q;
        srok_n = srok_q;
        mode_n = mode_q;
        if (pc_n == '0) begin
            d_n    = duty_i;
            ton_n  = ton_i;
            toff_n = toff_i;
            skip_n = duty_i < dmin_i;
            srok_n = (SW'(duty_i) + SW'(toff_i) + SW'(ton_i)) < SW'(P);
            if (duty_i < dmin_i)        mode_n = MODE_SKIP;
            else if (ton_i == min_ton_i) mode_n = MODE_CCM;
            else                         mode_n = MODE_DCM;
        end
    end

    // SR set and reset edges: set at D+td_off, reset at P-td_on.
    always_comb begin
        s_edge = SW'(d_n) + SW'(toff_n);
        r_edge = SW'(P) - SW'(ton_n);
        pwm_n  = !skip_n && (pc_n < d_n);
        sr_n   = !skip_n && srok_n && (SW'(pc_n) >= s_edge) && (SW'(pc_n) < r_edge);
    end

    // Latched parameters and registered gate outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q    <= '0;
            ton_q  <= '0;
            toff_q <= '0;
            skip_q <= 1'b1;
            srok_q <= 1'b0;
            mode_q <= MODE_SKIP;
            pwm_q  <= 1'b0;
            sr_q   <= 1'b0;
        end else begin
            d_q    <= d_n;
            ton_q  <= ton_n;
            toff_q <= toff_n;
            skip_q <= skip_n;
            srok_q <= srok_n;
            mode_q <= mode_n;
            pwm_q  <= pwm_n;
            sr_q   <= sr_n;
        end
    end

    assign pwm_o  = pwm_q;
    assign sr_o   = sr_q;
    assign mode_o = mode_q;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_q && sr_q)); // R10
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SKIP) |-> (!pwm_q && !sr_q)); // R6
    AST_SR_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        !srok_q |-> !sr_q); // R7
    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_n != '0) |=> $stable(d_q)); // R9
endmodule

// File: rtl/sr_deadtime_ctrl.sv
// Top: shared period counter, configuration port and one slice per phase.
// Assumes the period is a power of two (2**CW counts) and NPH divides it.
module sr_deadtime_ctrl
    import srm_pkg::*;
#(
    parameter int NPH     = 4,
    parameter int CW      = 10,
    parameter int TW      = 10,
    parameter int LW      = 4,
    parameter int DEF_ON  = 2,
    parameter int DEF_OFF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    duty_i,
    input  logic [LW-1:0]    load_i,
    input  logic             ser_en_i,
    input  logic             ser_dat_i,
    output logic [NPH-1:0]   pwm_o,
    output logic [NPH-1:0]   sr_o,
    output logic [2*NPH-1:0] mode_o
);
    localparam int P    = 2 ** CW;
    localparam int PSTP = P / NPH;

    logic [CW-1:0] cnt_q, cnt_n;
    logic [TW-1:0] ton, toff, min_ton;
    logic [CW-1:0] dmin;

    assign cnt_n = cnt_q + 1'b1;

    // Free-running period counter shared by all phases.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
    end

    srm_cfg_port #(.CW(CW), .TW(TW), .DEF_ON(DEF_ON), .DEF_OFF(DEF_OFF)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_en_i  (ser_en_i),
        .ser_dat_i (ser_dat_i),
        .rd_idx_i  (load_i[LW-1 -: 4]),
        .rd_ton_o  (ton),
        .rd_toff_o (toff),
        .dmin_o    (dmin),
        .min_ton_o (min_ton)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        srm_phase_slice #(.CW(CW), .TW(TW), .OFS(p * PSTP)) slice_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_n_i   (cnt_n),
            .duty_i    (duty_i),
            .dmin_i    (dmin),
            .ton_i     (ton),
            .toff_i    (toff),
            .min_ton_i (min_ton),
            .pwm_o     (pwm_o[p]),
            .sr_o      (sr_o[p]),
            .mode_o    (mode_o[2*p +: 2])
        );
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(P - 1)) |=> (cnt_q == '0)); // R2
endmodule

// File: tb/sr_deadtime_ctrl_tb.sv
module sr_deadtime_ctrl_tb_top;
    localparam int NPH = 2, CW = 6, TW = 6, LW = 8;
    localparam int P = 64, FW = 5 + 2 * TW;

    logic clk = 0, rst_n = 0;
    logic [CW-1:0] duty = 0;
    logic [LW-1:0] load = 0;
    logic ser_en = 0, ser_dat = 0;
    logic [NPH-1:0] pwm, sr;
    logic [2*NPH-1:0] mode;
    logic [CW-1:0] tb_cnt;

    int n_tests = 0, n_fail = 0;
    int tb_ton [16];
    int tb_toff[16];
    int tb_dmin = 0;

    always #4 clk = ~clk;

    sr_deadtime_ctrl #(.NPH(NPH), .CW(CW), .TW(TW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .duty_i(duty), .load_i(load),
        .ser_en_i(ser_en), .ser_dat_i(ser_dat),
        .pwm_o(pwm), .sr_o(sr), .mode_o(mode));

    // Time reference: count 0 in the first cycle after reset release.
    always @(posedge clk) tb_cnt <= rst_n ? tb_cnt + 1'b1 : '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int addr, input int ton, input int toff, input int nbits);
        logic [FW-1:0] w;
        w = {5'(addr), TW'(ton), TW'(toff)};
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); ser_en = 1; ser_dat = w[FW-1-i];
        end
        @(negedge clk); ser_en = 0; ser_dat = 0;
        @(negedge clk);
    endtask

    function automatic int min_ton();
        int m = tb_ton[0];
        for (int e = 1; e < 16; e++) if (tb_ton[e] < m) m = tb_ton[e];
        return m;
    endfunction

    // Hold D and load steady, then compare every cycle of a full period.
    task automatic scn(input int d, input int idx, input string tag);
        int bad_p = 0, bad_s = 0, bad_m = 0, ap = 0, as_ = 0, am = 0, ep = 0, es = 0, em = 0;
        int ton, toff; bit skp, ok;
        @(negedge clk); duty = CW'(d); load = LW'((idx << 4) | 7);
        repeat (2 * P + 2) @(negedge clk);
        ton = tb_ton[idx]; toff = tb_toff[idx];
        skp = d < tb_dmin;
        ok  = (d + toff + ton) < P;
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            for (int p = 0; p < NPH; p++) begin
                int pc = (int'(tb_cnt) + p * (P / NPH)) % P;
                int xp = (!skp && pc < d) ? 1 : 0;
                int xs = (!skp && ok && pc >= d + toff && pc < P - ton) ? 1 : 0;
                int xm = skp ? 2 : ((ton == min_ton()) ? 0 : 1);
                if (pwm[p] !== xp[0]) begin bad_p++; ap = pwm[p]; ep = xp; end
                if (sr[p] !== xs[0]) begin bad_s++; as_ = sr[p]; es = xs; end
                if (int'(mode[2*p +: 2]) != xm) begin bad_m++; am = mode[2*p +: 2]; em = xm; end
            end
        end
        chk(bad_p == 0, {tag, " R2/R6 pwm"}, ap, ep);
        chk(bad_s == 0, {tag, " R3/R7 sr"}, as_, es);
        chk(bad_m == 0, {tag, " R8 mode"}, am, em);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int dl[6] = '{0, 1, 10, 31, 50, 63};
        int il[4] = '{0, 5, 12, 15};
        for (int e = 0; e < 16; e++) begin tb_ton[e] = 2; tb_toff[e] = 2; end
        repeat (3) @(negedge clk);
        chk(pwm == 0 && sr == 0, "R1 gates in reset", {pwm, sr}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(pwm == 0 && sr == 0, "R1 gates after reset", {pwm, sr}, 0);
        chk(mode == 4'b1010, "R1 mode SKIP after reset", mode, 4'b1010);
        scn(20, 0, "R1 default table");
        // R4: program distinct entries through the serial port
        for (int e = 0; e < 16; e++) begin
            tb_ton[e]  = (e < 4) ? 2 : 3 + 2 * e;
            tb_toff[e] = 1 + (e % 3);
            send(e, tb_ton[e], tb_toff[e], FW);
        end
        foreach (dl[i]) foreach (il[j]) scn(dl[i], il[j], "R4 sweep");
        // R6: minimum duty 10, boundary on both sides
        send(16, 0, 10, FW); tb_dmin = 10;
        scn(5, 5, "R6 below dmin");
        scn(10, 5, "R6 at dmin");
        scn(9, 0, "R6 just below");
        // R5: short frame, long frame and address 17 are ignored
        send(16, 0, 40, FW - 1);
        send(0, 20, 9, FW + 1);
        send(17, 30, 30, FW);
        scn(20, 0, "R5 ignored frames");
        scn(12, 1, "R5 entry1 kept");
        // R9: mid-period duty change waits for the next period of phase 0
        @(negedge clk); duty = 20; load = 8'h07;
        repeat (2 * P) @(negedge clk);
        while (tb_cnt != 10) @(negedge clk);
        duty = 40;
        while (tb_cnt != 30) @(negedge clk);
        chk(pwm[0] == 0, "R9 old duty kept", pwm[0], 0);
        @(negedge clk);
        while (tb_cnt != 30) @(negedge clk);
        chk(pwm[0] == 1, "R9 new duty next period", pwm[0], 1);
        // R10 checked in every sweep cycle via expected windows; spot check here
        chk(!(pwm[0] && sr[0]) && !(pwm[1] && sr[1]), "R10 no overlap", {pwm, sr}, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule